// File: doc/BRIEF.md
# SPI Flash Status Register and Write-Protection Guard

This block holds the status register of a serial NOR flash that sits behind an SPI slave port. It decodes three instructions: write-enable, read-status and write-status. It stores a status-write-lock bit, a three-bit protection level and a write-enable latch. The block combines these bits with an active-low write-protect pin. From that it decides whether a program, sector-erase or bulk-erase request may go ahead.

The SPI pins are oversampled on the system clock. SPI mode 0 is used: the slave captures input on the rising SCK edge and moves its output on the falling edge. The array side is modelled as a request port. A one-cycle request carries a kind and a target sector number, and the block answers with one registered grant or reject pulse. The array, its timing and all other instructions are outside this block.

Top module: `spi_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00, the data output is not enabled, and grant and reject are both low.
- R2: A read-status frame starts with opcode 0x05, sent MSB first. The output enable stays low during the eight opcode bits. From the falling edge after the eighth bit it stays high until chip select rises.
- R3: After a read-status opcode, the status byte is sent MSB first and repeats for as long as chip select stays low. Layout: bit 7 is the write-lock bit, bits 4:2 are the protection level, bit 1 is the write-enable latch, bit 0 is busy, and bits 6:5 read 0.
- R4: Opcode 0x06 sets the write-enable latch only when chip select rises after exactly 8 bits.
- R5: Opcode 0x01 followed by one data byte writes the write-lock bit (data bit 7) and the protection level (data bits 4:2). This happens only when chip select rises after exactly 16 bits and the write-enable latch is set. A committed write clears the latch. The other data bits are ignored.
- R6: A write-status frame has no effect when the latch is clear or when the bit count is not 16. An aborted frame leaves the latch unchanged.
- R7: When the write-lock bit is 1 and the write-protect pin is low, a write-status frame is ignored completely: the write-lock bit, the protection level and the latch all keep their values. With the pin high, the same frame is accepted.
- R8: Protection level n from 1 to 7 protects the top 2^(n-1) of the 64 sectors, so level 7 covers all of them. Program (kind 0) and sector erase (kind 1) are rejected for a sector inside the protected range and granted outside it.
- R9: Bulk erase (kind 2) is granted only when the protection level is 0.
- R10: Each request cycle gives exactly one grant or reject pulse on the next clock. Kind 3 is always rejected, and no pulse appears without a request.
- R11: Status bit 0 follows the busy input from the array side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| spi_miso_oe | output | 1 | Output enable for spi_miso; low means high impedance |
| wp_n | input | 1 | Write-protect pin, active low |
| array_busy | input | 1 | Program or erase in progress, shown as status bit 0 |
| req_valid | input | 1 | One-cycle array request strobe |
| req_kind | input | 2 | 0 program, 1 sector erase, 2 bulk erase, 3 reserved |
| req_sector | input | SECT_W | Sector number (upper address bits) of the target |
| req_grant | output | 1 | Request allowed |
| req_reject | output | 1 | Request refused |

## Verification
The hardest state to reach is hardware-locked mode with the write-enable latch set. A write-status frame must then be refused without clearing the latch, and the only way to see this from outside is a later status read. The stimulus first sets the write-lock bit while the pin is high. It then pulls the pin low, issues a write-enable, sends the write-status frame, and reads back the status to confirm that the latch is still set and the lock bits are unchanged. The region boundaries are covered by stepping through all eight protection levels. At each level the sectors on either side of the protected boundary are requested.

// File: rtl/spg_pkg.sv
package spg_pkg;
  localparam logic [7:0] OP_READ_STAT  = 8'h05;
  localparam logic [7:0] OP_WRITE_STAT = 8'h01;
  localparam logic [7:0] OP_WRITE_EN   = 8'h06;

  typedef enum logic [1:0] {
    REQ_PROGRAM = 2'd0,
    REQ_SECTOR  = 2'd1,
    REQ_BULK    = 2'd2,
    REQ_NONE    = 2'd3
  } req_kind_e;

  // status byte assembly: lock, two zero bits, level, latch, busy
  function automatic logic [7:0] pack_status(input logic lock, input logic [2:0] lvl,
                                             input logic latch, input logic busy);
    return {lock, 2'b00, lvl, latch, busy};
  endfunction
endpackage

// File: rtl/spg_sync.sv
module spg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spg_spi_port.sv
module spg_spi_port #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic [7:0]       tx_byte,
  input  logic             tx_en,
  output logic             byte_done,
  output logic [7:0]       rx_byte,
  output logic [1:0]       byte_num,
  output logic             frame_end,
  output logic [CNT_W-1:0] frame_bits,
  output logic             miso,
  output logic             miso_oe
);
  logic [2:0] pins_s;
  logic sck_s, cs_s, mosi_s;
  logic sck_q, cs_q;
  logic sck_rise, sck_fall, cs_rise;
  logic [6:0] shreg;
  logic [2:0] bit_in_byte;
  logic [1:0] byte_idx;
  logic [CNT_W-1:0] bit_cnt;
  logic [2:0] tx_idx;

  spg_sync #(.W(3), .STAGES(2), .RST(3'b010)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, cs_n, mosi}), .q(pins_s)
  );
  assign {sck_s, cs_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  // named edge events, used by the assertions below
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_rise  = cs_s & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg       <= '0;
      bit_in_byte <= '0;
      byte_idx    <= '0;
      bit_cnt     <= '0;
      tx_idx      <= '0;
      miso        <= 1'b0;
      miso_oe     <= 1'b0;
    end else if (cs_s) begin
      bit_in_byte <= '0;
      byte_idx    <= '0;
      bit_cnt     <= '0;
      tx_idx      <= '0;
      miso        <= 1'b0;
      miso_oe     <= 1'b0;
    end else begin
      if (sck_rise) begin
        shreg       <= {shreg[5:0], mosi_s};
        bit_in_byte <= bit_in_byte + 3'd1;
        if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
        if (bit_in_byte == 3'd7 && byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
      end
      if (sck_fall && tx_en) begin
        miso    <= tx_byte[~tx_idx];
        tx_idx  <= tx_idx + 3'd1;
        miso_oe <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_done  <= 1'b0;
      rx_byte    <= '0;
      byte_num   <= '0;
      frame_end  <= 1'b0;
      frame_bits <= '0;
    end else begin
      byte_done <= ~cs_s & sck_rise & (bit_in_byte == 3'd7);
      if (~cs_s && sck_rise && bit_in_byte == 3'd7) begin
        rx_byte  <= {shreg, mosi_s};
        byte_num <= byte_idx;
      end
      frame_end <= cs_rise;
      if (cs_rise) frame_bits <= bit_cnt;
    end
  end

  // R2: no output drive while deselected
  assert_hiz_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !miso_oe);
  // R2: no output drive during the opcode byte
  assert_hiz_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && byte_idx == 2'd0) |-> !miso_oe);
  // R3: output only moves on a falling SCK
  assert_miso_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !sck_fall) |=> $stable(miso));
endmodule

// File: rtl/spg_status_ctl.sv
module spg_status_ctl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_done,
  input  logic [7:0]       rx_byte,
  input  logic [1:0]       byte_num,
  input  logic             frame_end,
  input  logic [CNT_W-1:0] frame_bits,
  input  logic             wp_n_s,
  input  logic             busy,
  output logic [7:0]       status,
  output logic [2:0]       level,
  output logic             read_en
);
  import spg_pkg::*;

  logic [7:0] opcode;
  logic       op_valid;
  logic [3:0] data_q;   // {lock, level}
  logic       lock_q;
  logic [2:0] level_q;
  logic       latch_q;
  logic       hw_locked;
  logic       wren_hit, wrsr_frame, wr_commit;

  assign hw_locked  = lock_q & ~wp_n_s;
  assign wren_hit   = frame_end & op_valid & (opcode == OP_WRITE_EN)   & (frame_bits == CNT_W'(8));
  assign wrsr_frame = frame_end & op_valid & (opcode == OP_WRITE_STAT) & (frame_bits == CNT_W'(16));
  assign wr_commit  = wrsr_frame & latch_q & ~hw_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode   <= '0;
      op_valid <= 1'b0;
      data_q   <= '0;
      read_en  <= 1'b0;
    end else if (frame_end) begin
      op_valid <= 1'b0;
      read_en  <= 1'b0;
    end else if (byte_done) begin
      if (byte_num == 2'd0) begin
        opcode   <= rx_byte;
        op_valid <= 1'b1;
        read_en  <= (rx_byte == OP_READ_STAT);
      end else if (byte_num == 2'd1) begin
        data_q <= {rx_byte[7], rx_byte[4:2]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      level_q <= '0;
      latch_q <= 1'b0;
    end else if (wr_commit) begin
      lock_q  <= data_q[3];
      level_q <= data_q[2:0];
      latch_q <= 1'b0;
    end else if (wren_hit) begin
      latch_q <= 1'b1;
    end
  end

  assign status = pack_status(lock_q, level_q, latch_q, busy);
  assign level  = level_q;

  // R7: locked mode freezes the non-volatile bits
  assert_hw_lock_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_locked |=> $stable({lock_q, level_q}));
  // R5: a committed write leaves the latch clear
  assert_latch_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !latch_q);
  // R6: non-volatile bits only change through a commit
  assert_nv_needs_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({lock_q, level_q}) |-> $past(wr_commit));
  // R4: the latch only rises after a write-enable frame
  assert_latch_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> $past(wren_hit));
endmodule

// File: rtl/spg_req_guard.sv
module spg_req_guard #(
  parameter int SECT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [SECT_W-1:0] req_sector,
  input  logic [2:0]        level,
  output logic              grant,
  output logic              reject
);
  import spg_pkg::*;

  localparam logic [SECT_W:0] ONE  = {{SECT_W{1'b0}}, 1'b1};
  localparam logic [SECT_W:0] FULL = ONE << SECT_W;

  // lowest protected sector; FULL means nothing is protected
  function automatic logic [SECT_W:0] floor_of(input logic [2:0] lvl);
    logic [SECT_W:0] span;
    int sh;
    sh = 7 - int'(lvl);
    if (lvl == 3'd0 || sh > SECT_W) span = '0;
    else span = ONE << (SECT_W - sh);
    return FULL - span;
  endfunction

  req_kind_e kind;
  logic [SECT_W:0] floor_sec;
  logic in_region, allow;

  assign kind      = req_kind_e'(req_kind);
  assign floor_sec = floor_of(level);
  assign in_region = {1'b0, req_sector} >= floor_sec;

  always_comb begin
    case (kind)
      REQ_PROGRAM, REQ_SECTOR: allow = ~in_region;
      REQ_BULK:                allow = (level == 3'd0);
      default:                 allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant  <= 1'b0;
      reject <= 1'b0;
    end else begin
      grant  <= req_valid & allow;
      reject <= req_valid & ~allow;
    end
  end

  // R10: exactly one answer per request, none otherwise
  assert_one_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant ^ reject));
  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(grant || reject));
  // R9: bulk erase refused at any nonzero level
  assert_bulk_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2 && level != 3'd0) |=> reject);
  // R8: level 7 covers every sector
  assert_full_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'd2 && level == 3'd7) |=> !grant);
endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard #(
  parameter int SECT_W = 6,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              wp_n,
  input  logic              array_busy,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [SECT_W-1:0] req_sector,
  output logic              req_grant,
  output logic              req_reject
);
  logic             byte_done, frame_end, read_en, wp_n_s;
  logic [7:0]       rx_byte, status;
  logic [1:0]       byte_num;
  logic [CNT_W-1:0] frame_bits;
  logic [2:0]       level;

  spg_sync #(.W(1), .STAGES(2), .RST(1'b1)) u_wp_sync (
    .clk(clk), .rst_n(rst_n), .d(wp_n), .q(wp_n_s)
  );

  spg_spi_port #(.CNT_W(CNT_W)) u_port (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_byte(status), .tx_en(read_en), .byte_done(byte_done), .rx_byte(rx_byte),
    .byte_num(byte_num), .frame_end(frame_end), .frame_bits(frame_bits),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spg_status_ctl #(.CNT_W(CNT_W)) u_status (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
    .byte_num(byte_num), .frame_end(frame_end), .frame_bits(frame_bits),
    .wp_n_s(wp_n_s), .busy(array_busy), .status(status), .level(level),
    .read_en(read_en)
  );

  spg_req_guard #(.SECT_W(SECT_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_sector(req_sector), .level(level), .grant(req_grant), .reject(req_reject)
  );
endmodule

// File: tb/test_spi_status_guard.sv
`timescale 1ns/1ps
module test_spi_status_guard;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic wp_n = 1'b1, array_busy = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [5:0] req_sector = '0;
  logic req_grant, req_reject;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_status_guard i_spi_status_guard (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .wp_n(wp_n), .array_busy(array_busy), .req_valid(req_valid),
    .req_kind(req_kind), .req_sector(req_sector), .req_grant(req_grant),
    .req_reject(req_reject)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic spi_frame(input logic [31:0] data, input int nbits,
                           output logic [31:0] rx, output logic [31:0] oe);
    rx = '0;
    oe = '0;
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = data[nbits-1-i];
      wait_clk(HALF);
      rx = {rx[30:0], spi_miso};
      oe = {oe[30:0], spi_miso_oe};
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    wait_clk(3*HALF);
  endtask

  task automatic read_status(output logic [7:0] first, output logic [7:0] second,
                             output logic [7:0] oe_op, output logic [15:0] oe_data);
    logic [31:0] rx, oe;
    spi_frame({8'h05, 16'h0000}, 24, rx, oe);
    first   = rx[15:8];
    second  = rx[7:0];
    oe_op   = oe[23:16];
    oe_data = oe[15:0];
  endtask

  task automatic expect_status(input string tag, input logic [7:0] exp);
    logic [7:0] a, b, o;
    logic [15:0] od;
    read_status(a, b, o, od);
    check(tag, {24'h0, a}, {24'h0, exp});
  endtask

  task automatic write_enable();
    logic [31:0] rx, oe;
    spi_frame({24'h0, 8'h06}, 8, rx, oe);
  endtask

  task automatic write_status(input logic [7:0] val);
    logic [31:0] rx, oe;
    spi_frame({16'h0, 8'h01, val}, 16, rx, oe);
  endtask

  task automatic do_req(input logic [1:0] kind, input int sec, input logic exp_grant, input string tag);
    logic g, r;
    req_kind   = kind;
    req_sector = sec[5:0];
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    g = req_grant;
    r = req_reject;
    check(tag, {30'h0, g, r}, {30'h0, exp_grant, ~exp_grant});
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 grant/reject idle", {30'h0, req_grant, req_reject}, 32'h0);
    check("R1 output enable idle", {31'h0, spi_miso_oe}, 32'h0);
    expect_status("R1 status after reset", 8'h00);
  endtask

  task automatic t_read_format();
    logic [7:0] a, b, o;
    logic [15:0] od;
    array_busy = 1'b1;
    wait_clk(2);
    read_status(a, b, o, od);
    check("R11 busy in bit 0", {24'h0, a}, 32'h01);
    check("R3 status repeats", {24'h0, b}, 32'h01);
    check("R2 hi-Z during opcode", {24'h0, o}, 32'h0);
    check("R2 driven during data", {16'h0, od}, 32'hFFFF);
    array_busy = 1'b0;
    wait_clk(2);
    expect_status("R11 busy cleared", 8'h00);
  endtask

  task automatic t_write_enable();
    logic [31:0] rx, oe;
    spi_frame({25'h0, 7'h03}, 7, rx, oe);
    expect_status("R4 short frame ignored", 8'h00);
    spi_frame({23'h0, 8'h06, 1'b0}, 9, rx, oe);
    expect_status("R4 long frame ignored", 8'h00);
    write_enable();
    expect_status("R4 latch set", 8'h02);
  endtask

  task automatic t_write_basic();
    write_status(8'h6F);
    expect_status("R5 write level 3, spare bits dropped, latch cleared", 8'h0C);
  endtask

  task automatic t_write_reject();
    logic [31:0] rx, oe;
    write_status(8'h00);
    expect_status("R6 no latch, write ignored", 8'h0C);
    write_enable();
    spi_frame({17'h0, 8'h01, 7'h00}, 15, rx, oe);
    expect_status("R6 15-bit write aborted", 8'h0E);
    spi_frame({15'h0, 8'h01, 8'h00, 1'b0}, 17, rx, oe);
    expect_status("R6 17-bit write aborted", 8'h0E);
    write_status(8'h00);
    expect_status("R6 16-bit write accepted", 8'h00);
  endtask

  task automatic t_hw_lock();
    write_enable();
    write_status(8'h90);
    expect_status("R7 lock set with pin high", 8'h90);
    wp_n = 1'b0;
    wait_clk(4);
    write_enable();
    expect_status("R7 latch still settable", 8'h92);
    write_status(8'h00);
    expect_status("R7 locked write ignored entirely", 8'h92);
    do_req(2'd2, 0, 1'b0, "R9 bulk refused at level 4");
    wp_n = 1'b1;
    wait_clk(4);
    write_status(8'h00);
    expect_status("R7 write accepted after pin high", 8'h00);
  endtask

  task automatic t_regions();
    for (int lvl = 0; lvl < 8; lvl++) begin
      int count, floor_s;
      logic [7:0] val;
      count   = (lvl == 0) ? 0 : (1 << (lvl - 1));
      floor_s = 64 - count;
      val = 8'(lvl << 2);
      write_enable();
      write_status(val);
      expect_status($sformatf("R5 level %0d stored", lvl), val);
      do_req(2'd0, 0, floor_s > 0, $sformatf("R8 program sector 0 level %0d", lvl));
      do_req(2'd1, 63, count == 0, $sformatf("R8 erase sector 63 level %0d", lvl));
      if (floor_s > 0)
        do_req(2'd0, floor_s - 1, 1'b1, $sformatf("R8 program below floor level %0d", lvl));
      if (floor_s < 64) begin
        do_req(2'd1, floor_s, 1'b0, $sformatf("R8 erase at floor level %0d", lvl));
        do_req(2'd0, floor_s, 1'b0, $sformatf("R8 program at floor level %0d", lvl));
      end
      do_req(2'd2, 5, lvl == 0, $sformatf("R9 bulk erase level %0d", lvl));
      do_req(2'd3, 0, 1'b0, $sformatf("R10 reserved kind level %0d", lvl));
    end
    check("R10 no pulse without request", {30'h0, req_grant, req_reject}, 32'h0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_read_format();
    t_write_enable();
    t_write_basic();
    t_write_reject();
    t_hw_lock();
    t_regions();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule